// File: doc/BRIEF.md
# Robbed-bit signaling receiver with freeze

This block recovers channel-associated signaling from a received T1/J1 stream that arrives one time-slot byte at a time. Each byte comes with a valid strobe, a frame-start marker and a multiframe-start marker. In every sixth frame of the signaling multiframe, the least significant bit of each time slot carries one signaling bit for its channel. The block gathers these bits into a shadow buffer. At the end of each complete multiframe it transfers the result into a packed store with four bits per channel.

Two frame formats are handled. In the 24-frame extended superframe, every channel carries four bits, A to D. In the 12-frame superframe, only A and B are carried, and the block copies them into the C and D positions.

A freeze state protects the store from corrupted data. It is entered on loss of signal, loss of frame alignment or a receive slip, unless automatic freeze has been switched off. An interrupt fires only when a committed multiframe differs from the stored one. A pointer names the first byte that changed, and a sticky vector records every changed byte. A separate interrupt marks multiframe resynchronisation, and a valid flag stays low until the first complete multiframe after it has been committed.

Top module: `rbs_sig_rx`

## Requirements
- R1: The signaling bits of a channel are taken from bit 0 of that channel's slot byte in frames 6, 12, 18 and 24 of the multiframe, counted from 1 at the byte flagged by mf_start_i. In the extended superframe these give A, B, C and D in that order. All other bits and frames have no effect on the store.
- R2: Channel n (numbered from 1) occupies one nibble of store_o, with bit 3 = A, bit 2 = B, bit 1 = C and bit 0 = D. Two channels share each byte. Byte 1 is store_o[8*N_BYTES-1 -: 8], and channel 1 sits in its upper nibble.
- R3: store_o changes only on the clock edge that takes in the last slot byte of the last frame of an in-sync multiframe (frame 12 in the superframe, frame 24 in the extended superframe). A multiframe that is cut short is never committed.
- R4: With esf_i = 0 (12-frame superframe), the bits from frames 6 and 12 become A and B, and each channel's nibble is stored as {A, B, A, B}.
- R5: With afreeze_dis_i = 0, any of los_i, lof_i or slip_i sets freeze_o on the next edge. A multiframe boundary that falls while freeze_o is high, or while an alarm input is high, does not update the store.
- R6: freeze_o clears at the end of the first complete multiframe that starts after the alarms have cleared and sees no alarm during its whole length. That multiframe itself is not committed.
- R7: With afreeze_dis_i = 1, the alarm inputs neither set freeze_o nor block commits, and freeze_o is low from the next edge on.
- R8: chg_irq_o pulses for one cycle with a commit only when the new store differs from the previous one. Committing identical data raises no pulse.
- R9: On a change pulse, chg_ptr_o holds the lowest-numbered changed byte, counting from 1. chg_vec_o bit j-1 is set for every changed byte j, accumulates over commits, and clears when chg_clr_i is asserted.
- R10: resync_irq_o pulses for one cycle when mf_start_i arrives at any point other than directly after the last slot of the last frame of an in-sync multiframe; the first marker after reset counts as such a point. valid_o drops at that point and rises at the commit of the first complete multiframe after it.
- R11: After reset, store_o, chg_vec_o, chg_ptr_o, freeze_o, valid_o and both interrupts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| esf_i | input | 1 | Format: 1 = 24-frame extended superframe, 0 = 12-frame superframe; sampled at the multiframe start |
| byte_vld_i | input | 1 | A time-slot byte is present this cycle |
| byte_i | input | 8 | Time-slot byte; bit 0 carries robbed bits |
| frame_start_i | input | 1 | Byte is slot 1 of a frame |
| mf_start_i | input | 1 | Byte is slot 1 of frame 1 of a multiframe |
| los_i | input | 1 | Loss of signal |
| lof_i | input | 1 | Loss of frame alignment |
| slip_i | input | 1 | Receive slip |
| afreeze_dis_i | input | 1 | Turns automatic freeze off |
| chg_clr_i | input | 1 | Clears the sticky change vector |
| store_o | output | 4*N_CH | Committed signaling, byte 1 at the top |
| freeze_o | output | 1 | Freeze active |
| valid_o | output | 1 | Store holds a full multiframe since the last resync |
| chg_irq_o | output | 1 | One-cycle pulse: committed signaling changed |
| chg_ptr_o | output | PTR_W | Lowest changed byte, numbered from 1 |
| chg_vec_o | output | N_CH/2 | Sticky changed-byte vector |
| resync_irq_o | output | 1 | One-cycle pulse on multiframe resync |

## Verification
The bench builds the block with N_CH = 4, which gives a 2-byte store and a 96-byte extended multiframe. At that size, freeze entry and release, both formats, a format switch at the boundary, and a two-step resync all fit into a few thousand cycles. Two store bytes are enough to cover both the case where the pointer must choose byte 1 over byte 2 and the case where only byte 2 changes. At the default of 24 channels, the same packing and priority logic is simply replicated by the generate loops.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  localparam int unsigned FRM_W     = 5;
  localparam int unsigned FRM_ESF   = 24;
  localparam int unsigned FRM_SF    = 12;
  localparam int unsigned NIB_W     = 4;

  typedef enum logic {FMT_SF = 1'b0, FMT_ESF = 1'b1} fmt_e;
endpackage

// File: rtl/rbs_slot_tracker.sv
module rbs_slot_tracker
  import rbs_pkg::*;
#(
  parameter int unsigned N_CH   = 24,
  localparam int unsigned SLOT_W = $clog2(N_CH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  fmt_e              fmt_i,
  input  logic              vld_i,
  input  logic              fs_i,
  input  logic              mfs_i,
  output fmt_e              fmt_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              sig_we_o,
  output logic [1:0]        sig_k_o,
  output logic              boundary_o,
  output logic              mf_begin_o,
  output logic              resync_o
);
  logic [FRM_W-1:0]  frame_q, frame_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              sync_q, sync_d;
  fmt_e              fmt_q;
  logic [FRM_W-1:0]  last_q, last_cur;
  logic              at_wrap, hit;

  assign fmt_o    = (vld_i && mfs_i) ? fmt_i : fmt_q;
  assign last_q   = (fmt_q == FMT_ESF) ? FRM_W'(FRM_ESF - 1) : FRM_W'(FRM_SF - 1);
  assign last_cur = (fmt_o == FMT_ESF) ? FRM_W'(FRM_ESF - 1) : FRM_W'(FRM_SF - 1);
  assign at_wrap  = sync_q && frame_q == last_q && slot_q == SLOT_W'(N_CH - 1);

  always_comb begin
    frame_d = frame_q;
    slot_d  = slot_q;
    sync_d  = sync_q;
    if (vld_i) begin
      if (mfs_i) begin
        frame_d = '0;
        slot_d  = '0;
        sync_d  = 1'b1;
      end else if (fs_i) begin
        slot_d = '0;
        if (frame_q >= last_q) sync_d = 1'b0;
        if (frame_q != '1) frame_d = frame_q + 1'b1;
      end else if (slot_q != '1) begin
        slot_d = slot_q + 1'b1;
      end
    end
  end

  always_comb begin
    hit     = 1'b1;
    sig_k_o = 2'd0;
    case (frame_d)
      5'd5:    sig_k_o = 2'd0;
      5'd11:   sig_k_o = 2'd1;
      5'd17:   sig_k_o = 2'd2;
      5'd23:   sig_k_o = 2'd3;
      default: hit = 1'b0;
    endcase
  end

  assign slot_o     = slot_d;
  assign sig_we_o   = vld_i && sync_d && hit && frame_d <= last_cur && slot_d < SLOT_W'(N_CH);
  assign boundary_o = vld_i && sync_d && frame_d == last_cur && slot_d == SLOT_W'(N_CH - 1);
  assign mf_begin_o = vld_i && mfs_i;
  assign resync_o   = vld_i && mfs_i && !at_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      slot_q  <= '0;
      sync_q  <= 1'b0;
      fmt_q   <= FMT_SF;
    end else begin
      frame_q <= frame_d;
      slot_q  <= slot_d;
      sync_q  <= sync_d;
      fmt_q   <= fmt_o;
    end
  end
endmodule

// File: rtl/rbs_freeze_ctl.sv
module rbs_freeze_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic alarm_i,
  input  logic auto_dis_i,
  input  logic mf_begin_i,
  input  logic boundary_i,
  output logic freeze_o,
  output logic commit_ok_o
);
  logic freeze_q, clean_q;

  assign freeze_o    = freeze_q;
  assign commit_ok_o = !freeze_q && !(alarm_i && !auto_dis_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freeze_q <= 1'b0;
      clean_q  <= 1'b0;
    end else begin
      // a multiframe counts as clean only if it began with no alarm and saw none
      if (alarm_i)         clean_q <= 1'b0;
      else if (mf_begin_i) clean_q <= 1'b1;

      if (auto_dis_i)                         freeze_q <= 1'b0;
      else if (alarm_i)                       freeze_q <= 1'b1;
      else if (freeze_q && boundary_i && clean_q) freeze_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rbs_store.sv
module rbs_store
  import rbs_pkg::*;
#(
  parameter int unsigned N_CH    = 24,
  localparam int unsigned N_BYTES = N_CH / 2,
  localparam int unsigned PTR_W   = $clog2(N_BYTES + 1),
  localparam int unsigned SLOT_W  = $clog2(N_CH) + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  fmt_e                  fmt_i,
  input  logic                  sig_we_i,
  input  logic [1:0]            sig_k_i,
  input  logic [SLOT_W-1:0]     slot_i,
  input  logic                  bit_i,
  input  logic                  commit_i,
  input  logic                  chg_clr_i,
  output logic [4*N_CH-1:0]     store_o,
  output logic                  chg_irq_o,
  output logic [PTR_W-1:0]      chg_ptr_o,
  output logic [N_BYTES-1:0]    chg_vec_o
);
  logic [N_CH-1:0][NIB_W-1:0] sh_q, sh_d, st_q;
  logic [N_BYTES-1:0]         diff;
  logic [PTR_W-1:0]           ptr_c;

  always_comb begin
    sh_d = sh_q;
    if (sig_we_i) begin
      for (int c = 0; c < int'(N_CH); c++) begin
        if (slot_i == SLOT_W'(c)) begin
          if (fmt_i == FMT_ESF) begin
            sh_d[c][2'd3 - sig_k_i] = bit_i;
          end else if (sig_k_i == 2'd0) begin
            sh_d[c][3] = bit_i;
            sh_d[c][1] = bit_i;
          end else begin
            sh_d[c][2] = bit_i;
            sh_d[c][0] = bit_i;
          end
        end
      end
    end
  end

  for (genvar j = 0; j < N_BYTES; j++) begin : g_diff
    assign diff[j] = (sh_d[2*j] != st_q[2*j]) || (sh_d[2*j+1] != st_q[2*j+1]);
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_out
    assign store_o[4*(N_CH-1-c) +: 4] = st_q[c];
  end

  always_comb begin
    ptr_c = '0;
    for (int j = int'(N_BYTES) - 1; j >= 0; j--) begin
      if (diff[j]) ptr_c = PTR_W'(j + 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '0;
      st_q      <= '0;
      chg_irq_o <= 1'b0;
      chg_ptr_o <= '0;
      chg_vec_o <= '0;
    end else begin
      sh_q      <= sh_d;
      chg_irq_o <= 1'b0;
      chg_vec_o <= (chg_clr_i ? '0 : chg_vec_o) | (commit_i ? diff : '0);
      if (commit_i) begin
        st_q <= sh_d;
        if (|diff) begin
          chg_irq_o <= 1'b1;
          chg_ptr_o <= ptr_c;
        end
      end
    end
  end
endmodule

// File: rtl/rbs_sig_rx.sv
module rbs_sig_rx
  import rbs_pkg::*;
#(
  parameter int unsigned N_CH    = 24,
  localparam int unsigned N_BYTES = N_CH / 2,
  localparam int unsigned PTR_W   = $clog2(N_BYTES + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 esf_i,
  input  logic                 byte_vld_i,
  input  logic [7:0]           byte_i,
  input  logic                 frame_start_i,
  input  logic                 mf_start_i,
  input  logic                 los_i,
  input  logic                 lof_i,
  input  logic                 slip_i,
  input  logic                 afreeze_dis_i,
  input  logic                 chg_clr_i,
  output logic [4*N_CH-1:0]    store_o,
  output logic                 freeze_o,
  output logic                 valid_o,
  output logic                 chg_irq_o,
  output logic [PTR_W-1:0]     chg_ptr_o,
  output logic [N_BYTES-1:0]   chg_vec_o,
  output logic                 resync_irq_o
);
  localparam int unsigned SLOT_W = $clog2(N_CH) + 1;

  fmt_e              fmt_cur;
  logic [SLOT_W-1:0] slot;
  logic              sig_we, boundary, mf_begin, resync, commit_ok, commit;
  logic [1:0]        sig_k;
  logic              unused_bits;

  assign unused_bits = ^byte_i[7:1];

  rbs_slot_tracker #(.N_CH(N_CH)) u_trk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fmt_i      (esf_i ? FMT_ESF : FMT_SF),
    .vld_i      (byte_vld_i),
    .fs_i       (frame_start_i),
    .mfs_i      (mf_start_i),
    .fmt_o      (fmt_cur),
    .slot_o     (slot),
    .sig_we_o   (sig_we),
    .sig_k_o    (sig_k),
    .boundary_o (boundary),
    .mf_begin_o (mf_begin),
    .resync_o   (resync)
  );

  rbs_freeze_ctl u_frz (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alarm_i     (los_i | lof_i | slip_i),
    .auto_dis_i  (afreeze_dis_i),
    .mf_begin_i  (mf_begin),
    .boundary_i  (boundary),
    .freeze_o    (freeze_o),
    .commit_ok_o (commit_ok)
  );

  assign commit = boundary && commit_ok;

  rbs_store #(.N_CH(N_CH)) u_st (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fmt_i     (fmt_cur),
    .sig_we_i  (sig_we),
    .sig_k_i   (sig_k),
    .slot_i    (slot),
    .bit_i     (byte_i[0]),
    .commit_i  (commit),
    .chg_clr_i (chg_clr_i),
    .store_o   (store_o),
    .chg_irq_o (chg_irq_o),
    .chg_ptr_o (chg_ptr_o),
    .chg_vec_o (chg_vec_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      resync_irq_o <= 1'b0;
    end else begin
      resync_irq_o <= resync;
      if (resync)      valid_o <= 1'b0;
      else if (commit) valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rbs_sig_rx_chk.sv
module rbs_sig_rx_chk #(
  parameter int unsigned N_CH    = 24,
  localparam int unsigned N_BYTES = N_CH / 2,
  localparam int unsigned PTR_W   = $clog2(N_BYTES + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               byte_vld_i,
  input logic               afreeze_dis_i,
  input logic [4*N_CH-1:0]  store_o,
  input logic               freeze_o,
  input logic               valid_o,
  input logic               chg_irq_o,
  input logic [PTR_W-1:0]   chg_ptr_o,
  input logic [N_BYTES-1:0] chg_vec_o,
  input logic               resync_irq_o
);
  AST_STORE_ON_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(store_o) |-> $past(byte_vld_i)); // R3

  AST_FROZEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_o |=> $stable(store_o)); // R5

  AST_AUTO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(afreeze_dis_i) |-> !freeze_o); // R7

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_irq_o |=> !chg_irq_o); // R8

  AST_IRQ_REAL_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_irq_o |-> store_o != $past(store_o)); // R8

  AST_PTR_IN_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_irq_o |-> (chg_ptr_o >= PTR_W'(1) && chg_ptr_o <= PTR_W'(N_BYTES)
                   && chg_vec_o[chg_ptr_o - 1'b1])); // R9

  AST_RESYNC_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_irq_o |-> !valid_o); // R10
endmodule

bind rbs_sig_rx rbs_sig_rx_chk #(.N_CH(N_CH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .byte_vld_i    (byte_vld_i),
  .afreeze_dis_i (afreeze_dis_i),
  .store_o       (store_o),
  .freeze_o      (freeze_o),
  .valid_o       (valid_o),
  .chg_irq_o     (chg_irq_o),
  .chg_ptr_o     (chg_ptr_o),
  .chg_vec_o     (chg_vec_o),
  .resync_irq_o  (resync_irq_o)
);

// File: tb/rbs_sig_rx_test.sv
module rbs_sig_rx_test;
  localparam int N_CH = 4;
  localparam int NB   = N_CH / 2;
  localparam int PW   = $clog2(NB + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic esf = 1'b1, vld = 1'b0, fs = 1'b0, mfs = 1'b0;
  logic [7:0] data = '0;
  logic los = 1'b0, lof = 1'b0, slip = 1'b0, adis = 1'b0, clr = 1'b0;
  logic [4*N_CH-1:0] store;
  logic freeze, valid, irq, rsirq;
  logic [PW-1:0] ptr;
  logic [NB-1:0] vec;

  int checks = 0, errors = 0, irq_cnt = 0, rs_cnt = 0;

  typedef struct packed {logic [15:0] st; logic [PW-1:0] ptr;} exp_t;
  exp_t exp_q[$];
  logic [15:0] model_st = '0;

  always #4 clk = ~clk;

  rbs_sig_rx #(.N_CH(N_CH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .esf_i(esf), .byte_vld_i(vld), .byte_i(data),
    .frame_start_i(fs), .mf_start_i(mfs), .los_i(los), .lof_i(lof), .slip_i(slip),
    .afreeze_dis_i(adis), .chg_clr_i(clr), .store_o(store), .freeze_o(freeze),
    .valid_o(valid), .chg_irq_o(irq), .chg_ptr_o(ptr), .chg_vec_o(vec),
    .resync_irq_o(rsirq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard driver side: queue the pulse a commit of new_st should produce
  task automatic expect_commit(input logic [15:0] new_st);
    exp_t e;
    if (new_st != model_st) begin
      e.st  = new_st;
      e.ptr = (new_st[15:8] != model_st[15:8]) ? PW'(1) : PW'(2);
      exp_q.push_back(e);
    end
    model_st = new_st;
  endtask

  // monitor: every change pulse is matched against the queue (R8, R9)
  always @(negedge clk) begin
    if (rst_n && rsirq) rs_cnt++;
    if (rst_n && irq) begin
      irq_cnt++;
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 actual pulse expected none (store %h)", store);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check("R8 store at pulse", 32'(store), 32'(e.st));
        check("R9 pointer", 32'(ptr), 32'(e.ptr));
      end
    end
  end

  function automatic logic [15:0] sf_exp(input logic [15:0] s);
    logic [15:0] r;
    for (int c = 0; c < 4; c++) begin
      r[4*c+3] = s[4*c+3]; r[4*c+1] = s[4*c+3];
      r[4*c+2] = s[4*c+2]; r[4*c+0] = s[4*c+2];
    end
    return r;
  endfunction

  // al_sel: 0 los, 1 lof, 2 slip
  task automatic send_mf(input bit fmt, input logic [15:0] sig, input int nfr,
                         input int al_frame, input int al_sel);
    for (int f = 0; f < nfr; f++) begin
      for (int s = 0; s < N_CH; s++) begin
        logic [3:0] nib;
        logic lsb;
        nib = sig[4*(3-s) +: 4];
        lsb = ((f % 6) == 5) ? nib[3 - f/6] : 1'((f + s) & 1);
        @(negedge clk);
        esf  = fmt;
        vld  = 1'b1;
        data = {7'(f * 3 + s + 7'h2a), lsb};
        fs   = (s == 0);
        mfs  = (s == 0 && f == 0);
        los  = (f == al_frame && s == 0 && al_sel == 0);
        lof  = (f == al_frame && s == 0 && al_sel == 1);
        slip = (f == al_frame && s == 0 && al_sel == 2);
      end
    end
    @(negedge clk);
    vld = 1'b0; fs = 1'b0; mfs = 1'b0; los = 1'b0; lof = 1'b0; slip = 1'b0;
  endtask

  task automatic pulse_clr;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 store", 32'(store), 0);
    check("R11 valid/freeze/irqs", {valid, freeze, irq, rsirq}, 0);
    check("R11 vec/ptr", {vec, ptr}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R10: first extended multiframe after reset
    expect_commit(16'h5A3C);
    send_mf(1'b1, 16'h5A3C, 24, -1, 0);
    check("R1 R2 store", 32'(store), 32'h5A3C);
    check("R10 valid after full mf", 32'(valid), 1);
    check("R10 resync count", rs_cnt, 1);
    check("R9 vec both", 32'(vec), 32'b11);

    // R8: same data, no pulse; R9 clear
    pulse_clr();
    check("R9 vec cleared", 32'(vec), 0);
    send_mf(1'b1, 16'h5A3C, 24, -1, 0);
    check("R8 no pulse on equal data", irq_cnt, 1);
    check("R9 vec still clear", 32'(vec), 0);

    // R9: byte 2 only
    expect_commit(16'h5A3D);
    send_mf(1'b1, 16'h5A3D, 24, -1, 0);
    check("R9 vec byte2", 32'(vec), 32'b10);
    check("R9 ptr byte2", 32'(ptr), 2);

    // R4: superframe, switch at boundary must not resync
    expect_commit(sf_exp(16'h84C0));
    send_mf(1'b0, 16'h84C0, 12, -1, 0);
    check("R4 repeated bits", 32'(store), 32'hA5F0);
    check("R10 no resync on format switch", rs_cnt, 1);

    // R5 R6: loss of signal
    send_mf(1'b0, 16'h0000, 12, 3, 0);
    check("R5 freeze on los", 32'(freeze), 1);
    check("R5 store held", 32'(store), 32'hA5F0);
    send_mf(1'b0, 16'h0000, 12, -1, 0);
    check("R6 freeze released", 32'(freeze), 0);
    check("R6 release mf not committed", 32'(store), 32'hA5F0);
    expect_commit(16'h0000);
    send_mf(1'b0, 16'h0000, 12, -1, 0);
    check("R6 commit after release", 32'(store), 0);

    // R5: slip late in an extended multiframe
    send_mf(1'b1, 16'h1234, 24, 20, 2);
    check("R5 freeze on slip", 32'(freeze), 1);
    check("R5 store held slip", 32'(store), 0);
    send_mf(1'b1, 16'h1234, 24, -1, 0);
    check("R6 freeze released esf", 32'(freeze), 0);
    expect_commit(16'h1234);
    send_mf(1'b1, 16'h1234, 24, -1, 0);
    check("R3 commit at boundary", 32'(store), 32'h1234);

    // R7: auto freeze off
    adis = 1'b1;
    expect_commit(16'h1235);
    send_mf(1'b1, 16'h1235, 24, 2, 1);
    check("R7 no freeze", 32'(freeze), 0);
    check("R7 commit despite lof", 32'(store), 32'h1235);
    adis = 1'b0;

    // R3 R10: partial multiframes and resync
    send_mf(1'b1, 16'hFFFF, 8, -1, 0);
    check("R3 partial not committed", 32'(store), 32'h1235);
    check("R10 no resync yet", rs_cnt, 1);
    send_mf(1'b1, 16'hFFFF, 3, -1, 0);
    check("R10 resync pulse", rs_cnt, 2);
    check("R10 valid low", 32'(valid), 0);
    expect_commit(16'h0F0F);
    send_mf(1'b1, 16'h0F0F, 24, -1, 0);
    check("R10 valid again", 32'(valid), 1);
    check("R1 store after resync", 32'(store), 32'h0F0F);

    repeat (3) @(negedge clk);
    check("R8 all pulses seen", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule